// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch is taken using only the recent history of predicted branch directions. An 8-bit global history register selects one of 256 two-bit saturating counters. The most significant bit of the selected counter is the taken prediction. The prediction is combinational from the current history. The history value used for a prediction is presented beside it, so the pipeline can carry it with the branch.

When the front end accepts a prediction, it pulses `pred_shift`. The history register then shifts in the predicted direction. History is therefore speculative.

When a branch resolves, the pipeline returns three things: the known flag, the real outcome and the history that travelled with the branch. The counter at that history index is then trained. This index may differ from the current history.

On a misprediction, the pipeline supplies the checkpointed history of the failing branch together with its real outcome. The history register then becomes that checkpoint shifted left by one with the outcome in bit 0. This discards every younger speculative shift.

Each counter is a four-state machine:
- `CTR_SNT` (strong not-taken, 0)
- `CTR_WNT` (weak not-taken, 1)
- `CTR_WT` (weak taken, 2)
- `CTR_ST` (strong taken, 3)

The transition `train_up` moves one state toward `CTR_ST`, and `CTR_ST` stays put. The transition `train_down` moves one state toward `CTR_SNT`, and `CTR_SNT` stays put.

The history register has three named modes:
- `HIST_HOLD`: keep the value.
- `HIST_SHIFT`: shift in the prediction.
- `HIST_RESTORE`: load the corrected checkpoint.

Mode priority is restore, then shift, then hold.

Top module: `ghist_predictor`

## Requirements
- R1: After reset the history register is 0 and every counter is in `CTR_WNT` (value 1), so the prediction is 0 for any history value.
- R2: `pred_taken` equals bit 1 of the counter indexed by the current history, and `pred_hist` equals the current history, both combinationally.
- R3: When `pred_shift` is high and `fix_valid` is low, the next history is `{hist[6:0], pred_taken}`.
- R4: When neither `pred_shift` nor `fix_valid` is high, the history keeps its value.
- R5: When `fix_valid` is high, the next history is `{fix_hist[6:0], fix_taken}`.
- R6: When `fix_valid` and `pred_shift` are both high, the restore of R5 wins and the shift is discarded.
- R7: A resolve with `res_valid` high and `res_taken` high raises the counter at index `res_hist` by one, saturating at 3.
- R8: A resolve with `res_valid` high and `res_taken` low lowers the counter at index `res_hist` by one, saturating at 0.
- R9: A resolve changes only the counter at `res_hist`. All other counters, and the history register, are unaffected by it.
- R10: When a resolve trains the entry that the current history selects, `pred_taken` in that same cycle shows the value before the update. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_shift | input | 1 | Prediction accepted; shift the predicted direction into the history |
| pred_taken | output | 1 | Predicted direction for the current history (1 = taken) |
| pred_hist | output | 8 | Current history, to travel with the branch |
| res_valid | input | 1 | Branch outcome known this cycle |
| res_taken | input | 1 | Real branch outcome (1 = taken) |
| res_hist | input | 8 | History that was used to predict the resolving branch |
| fix_valid | input | 1 | Misprediction; restore the history |
| fix_hist | input | 8 | Checkpointed history of the mispredicted branch |
| fix_taken | input | 1 | Real outcome of the mispredicted branch |

## Verification
Two groups of properties are checked on every cycle:
- History transitions: hold, shift with the current prediction, and restore from the checkpoint with priority over shift.
- Counter training: each counter's saturating step on a train, and its stability when not addressed.

Other behaviour is shown only by the bench's scenarios:
- The end-to-end link between a resolve at one history and a later prediction at that history.
- Isolation between entries.
- The reset contents of the table.
- The same-cycle read-before-update ordering.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_state_t;

    typedef enum logic [1:0] {
        HIST_HOLD    = 2'd0,
        HIST_SHIFT   = 2'd1,
        HIST_RESTORE = 2'd2
    } hist_mode_t;

    // One training step of a saturating counter (train_up / train_down)
    function automatic ctr_state_t ctr_step(ctr_state_t cur, logic up);
        ctr_state_t nxt;
        unique case (cur)
            CTR_SNT: nxt = up ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = up ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = up ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = up ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpred_counter.sv
module gpred_counter
    import gpred_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       train_en,
    input  logic       train_up,
    output ctr_state_t state
);

    ctr_state_t state_q;
    ctr_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTR_WNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (train_en) state_d = ctr_step(state_q, train_up);
    end

    assign state = state_q;

    // R7
    train_up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && train_up) |=>
            (state_q == CTR_ST) && ($past(state_q) >= CTR_WT) ||
            (state_q == ctr_state_t'($past(state_q) + 2'd1)));

    // R8
    train_down_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !train_up) |=>
            (state_q == CTR_SNT) && ($past(state_q) <= CTR_WNT) ||
            (state_q == ctr_state_t'($past(state_q) - 2'd1)));

    // R9
    untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> $stable(state_q));

endmodule

// File: rtl/gpred_table.sv
module gpred_table
    import gpred_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic             wr_taken,
    input  logic [IDX_W-1:0] wr_idx
);

    localparam int ENTRIES = 1 << IDX_W;

    ctr_state_t ctr_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        gpred_counter u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .train_en (wr_en && (wr_idx == IDX_W'(g))),
            .train_up (wr_taken),
            .state    (ctr_q[g])
        );
    end

    // read reflects registered state: pre-update on same-index collision
    ctr_state_t rd_state;
    always_comb begin
        rd_state = ctr_q[rd_idx];
        rd_taken = rd_state[1];
    end

endmodule

// File: rtl/gpred_history.sv
module gpred_history
    import gpred_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;
    hist_mode_t        mode;

    always_comb begin
        if (fix_en)        mode = HIST_RESTORE;
        else if (shift_en) mode = HIST_SHIFT;
        else               mode = HIST_HOLD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // next value per mode
    always_comb begin
        unique case (mode)
            HIST_RESTORE: hist_d = {fix_hist[HIST_W-2:0], fix_bit};
            HIST_SHIFT:   hist_d = {hist_q[HIST_W-2:0], shift_bit};
            HIST_HOLD:    hist_d = hist_q;
            default:      hist_d = hist_q;
        endcase
    end

    assign hist = hist_q;

    // R5 R6
    restore_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> hist_q == {$past(fix_hist[HIST_W-2:0]), $past(fix_bit)});

    // R3
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !fix_en) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)});

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !fix_en) |=> $stable(hist_q));

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor
    import gpred_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_shift,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              res_valid,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_hist,
    input  logic              fix_valid,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_taken
);

    logic [HIST_W-1:0] cur_hist;
    logic              guess;

    gpred_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (pred_shift),
        .shift_bit (guess),
        .fix_en    (fix_valid),
        .fix_hist  (fix_hist),
        .fix_bit   (fix_taken),
        .hist      (cur_hist)
    );

    gpred_table #(.IDX_W(HIST_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_hist),
        .rd_taken (guess),
        .wr_en    (res_valid),
        .wr_taken (res_taken),
        .wr_idx   (res_hist)
    );

    assign pred_taken = guess;
    assign pred_hist  = cur_hist;

    // R9: a resolve alone never moves the history
    resolve_no_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !pred_shift && !fix_valid) |=> $stable(pred_hist));

endmodule

// File: tb/tb_ghist_predictor.sv
module tb_ghist_predictor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pred_shift = 1'b0;
    logic       pred_taken;
    logic [7:0] pred_hist;
    logic       res_valid = 1'b0;
    logic       res_taken = 1'b0;
    logic [7:0] res_hist = '0;
    logic       fix_valid = 1'b0;
    logic [7:0] fix_hist = '0;
    logic       fix_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2ns clk = ~clk;

    ghist_predictor dut (
        .clk(clk), .rst_n(rst_n), .pred_shift(pred_shift),
        .pred_taken(pred_taken), .pred_hist(pred_hist),
        .res_valid(res_valid), .res_taken(res_taken), .res_hist(res_hist),
        .fix_valid(fix_valid), .fix_hist(fix_hist), .fix_taken(fix_taken)
    );

    typedef struct packed {
        logic       sh;
        logic       fx;
        logic [7:0] fh;
        logic       ft;
        logic       rv;
        logic       rt;
        logic [7:0] rh;
        logic [7:0] eh;
        logic       ep;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 18;
    // sh fx fh ft rv rt rh  -> expected hist, pred after the edge
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h00, 8'h00,1'b1,4'd7}, // R7 ctr[0] 1->2
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,8'h00, 8'h01,1'b0,4'd3}, // R3 shift in 1
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,8'h00, 8'h02,1'b0,4'd3}, // R3 shift in 0
        '{1'b1,1'b1,8'h81,1'b1,1'b0,1'b0,8'h00, 8'h03,1'b0,4'd6}, // R6 restore beats shift
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h03, 8'h03,1'b1,4'd7}, // R7 1->2
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h03, 8'h03,1'b1,4'd7}, // R7 2->3
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h03, 8'h03,1'b1,4'd7}, // R7 saturate 3
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03, 8'h03,1'b1,4'd8}, // R8 3->2
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03, 8'h03,1'b0,4'd8}, // R8 2->1
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03, 8'h03,1'b0,4'd8}, // R8 1->0
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h03, 8'h03,1'b0,4'd8}, // R8 saturate 0
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h03, 8'h03,1'b0,4'd8}, // R8 0->1 still NT
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,8'h00, 8'h03,1'b0,4'd4}, // R4 hold
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h00, 8'h03,1'b0,4'd9}, // R9 other entry trained
        '{1'b0,1'b1,8'h7F,1'b0,1'b0,1'b0,8'h00, 8'hFE,1'b0,4'd5}, // R5 restore
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,8'h00, 8'hFC,1'b0,4'd3}, // R3 shift in 0
        '{1'b0,1'b1,8'h80,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b1,4'd5}, // R5 back to 0, ctr[0]=3
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,8'h00, 8'h01,1'b0,4'd2}  // R2 shift taken
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pred_shift = 0; fix_valid = 0; fix_hist = '0; fix_taken = 0;
        res_valid = 0; res_taken = 0; res_hist = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic restore_to(input logic [7:0] h);
        fix_valid = 1; fix_hist = {1'b0, h[7:1]}; fix_taken = h[0];
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 hist", pred_hist, 8'h00);
        check("R1 pred", {7'b0, pred_taken}, 8'h00);
        foreach (VECS[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] h;
            h = 8'(k * 8'h55 + 8'h11);
            restore_to(h);
            check("R1 entry weak-NT", {7'b0, pred_taken}, 8'h00);
            check("R5 hist", pred_hist, h);
        end

        do_reset();
        for (int i = 0; i < NV; i++) begin
            pred_shift = VECS[i].sh;
            fix_valid  = VECS[i].fx;
            fix_hist   = VECS[i].fh;
            fix_taken  = VECS[i].ft;
            res_valid  = VECS[i].rv;
            res_taken  = VECS[i].rt;
            res_hist   = VECS[i].rh;
            @(negedge clk);
            idle_inputs();
            check($sformatf("R%0d hist v%0d", VECS[i].tag, i), pred_hist, VECS[i].eh);
            check($sformatf("R%0d pred v%0d", VECS[i].tag, i), {7'b0, pred_taken}, {7'b0, VECS[i].ep});
        end

        // R10: same-cycle train of the selected entry shows old value
        restore_to(8'h5A);
        res_valid = 1; res_taken = 1; res_hist = 8'h5A;
        #1ns;
        check("R10 pre-update read", {7'b0, pred_taken}, 8'h00);
        @(negedge clk);
        idle_inputs();
        check("R10 post-update read", {7'b0, pred_taken}, 8'h01);

        // R9: training 0x33 twice leaves neighbour 0x34 untouched
        restore_to(8'h34);
        res_valid = 1; res_taken = 1; res_hist = 8'h33;
        @(negedge clk);
        @(negedge clk);
        idle_inputs();
        check("R9 neighbour unchanged", {7'b0, pred_taken}, 8'h00);
        check("R9 hist unchanged", pred_hist, 8'h34);
        restore_to(8'h33);
        check("R9 trained entry", {7'b0, pred_taken}, 8'h01);

        // R2: shift uses live prediction (entry 0x33 taken)
        pred_shift = 1;
        @(negedge clk);
        idle_inputs();
        check("R2 shifted prediction", pred_hist, 8'h67);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule